// File: doc/BRIEF.md
# Three-Wire Control Port Register Slave

This block is the slave side of a serial control port built from three wires: a serial clock, a mode line and a bidirectional data line. A host frames each access as an address phase (mode LOW), where one byte selects the device and the kind of operation, followed by a data phase (mode HIGH), where the bytes name a register and carry its 16-bit contents. The slave keeps a bank of 16-bit configuration registers with 7-bit addresses. It presents every register in parallel to the surrounding logic and returns register contents over the data line when the host reads.

All three serial wires are brought into the system clock domain through a synchronizer, and the system clock then samples them. The serial clock must run well below the system clock: each half period must last at least five system clocks. The mode line may change only while the serial clock is low. The bank also applies three rules of its own. A control bit clears the whole bank. A status word from the outside world appears at one read-only address. A write to the shared channel-feature register is copied into six per-channel registers.

Top module: `ctl3_slave`

## Requirements
- R1: In the address phase (mode LOW) the slave shifts in 8 bits, MSB first, on rising serial clock edges. Bits [5:0] must equal the device address 6'b010100. Bits [7:6] select the operation: 2'b01 is a command and 2'b11 is a read-back. Any other prefix, or a different device address, selects nothing.
- R2: After a command address, the data phase takes three bytes. The first byte has bit 7 = 0 and carries the register address in bits [6:0]. The second byte is the upper half of the data and the third byte is the lower half. The register takes the 16-bit value after the third byte, and no register changes at any other time.
- R3: A read is six bytes. The host sends a command address, then a register byte with bit 7 = 1 that names the register to read. It then sends a read-back address and a register byte again. The slave then shifts out the 16-bit contents, MSB first, in two data bytes. Each bit is valid before the rising edge that samples it.
- R4: The data line enable is high only during the two returned data bytes of a read. At all other times the slave releases the line and drives its data output low.
- R5: When the address byte does not match, every data-phase byte is ignored until the next address phase. No register changes and the line stays released.
- R6: Writing register 00h with bit 15 = 1 returns every register to its default value of 0000h, register 00h included.
- R7: Reads of register 0Fh return the `status_i` input. Writes to 0Fh change no register. The parallel slot for 0Fh is always 0000h.
- R8: A write to register 11h stores the value there and copies it whole into the odd-channel registers 12h, 14h and 16h. It also copies it into the even-channel registers 13h, 15h and 17h, except bits [15:14], which keep their previous value in those three registers.
- R9: Register addresses from 20h upward are not implemented. Writes to them change nothing and reads of them return 0000h.
- R10: While `rst_ni` is low, every register is 0000h and the data line is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctl_clk_i | input | 1 | Serial control clock |
| ctl_mode_i | input | 1 | Phase select: LOW for the address phase, HIGH for the data phase |
| ctl_data_i | input | 1 | Serial data from the host |
| status_i | input | 16 | Status word returned by reads of 0Fh |
| ctl_data_o | output | 1 | Serial data driven back to the host during reads |
| ctl_data_oe_o | output | 1 | Enable for the slave's drive of the data line |
| regs_o | output | 512 | All registers in parallel; register n sits at bits [16n+15:16n] |

## Verification
The bench uses its own register model to check the cases a faulty decoder would get wrong. These include a mismatched device address or an unknown prefix: a design that ignored the prefix would corrupt register 05h or drive the line during a foreign read. Broadcast is checked against even-channel registers whose bits [15:14] were set beforehand. A design that copied the whole word would clear those bits, and one that skipped the even channels would leave them stale. The bench also checks that a write to 0Fh or to an address above 1Fh leaves the bank untouched. It checks that the reset bit wipes every register, including itself, and that the enable rises only for the 16 returned bits and not during the echo byte or after the last bit.

// File: rtl/ctl3_pkg.sv
package ctl3_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 7;
  localparam logic [1:0] OP_CMD  = 2'b01;
  localparam logic [1:0] OP_RDBK = 2'b11;
  localparam int RST_BIT = 15;
  localparam int SEL_HI  = 15;
  localparam int SEL_LO  = 14;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_CMD  = 2'd1,
    PH_RDBK = 2'd2
  } phase_e;
endpackage

// File: rtl/ctl3_sync.sv
module ctl3_sync #(
  parameter int STAGES = 2,
  parameter int W      = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] chain_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) chain_q[i] <= '0;
    end else begin
      chain_q[0] <= async_i;
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
    end
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/ctl3_frame.sv
module ctl3_frame
  import ctl3_pkg::*;
#(
  parameter logic [5:0] DEV_ADDR = 6'b010100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_s_i,
  input  logic              mode_s_i,
  input  logic              data_s_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              tx_o,
  output logic              oe_o
);
  logic              sclk_q, mode_q;
  logic [2:0]        bit_cnt_q;
  logic [1:0]        idx_q;
  logic [6:0]        sh_q;
  logic [7:0]        hi_q;
  logic              rd_flag_q;
  logic [DATA_W-1:0] tx_q;
  phase_e            phase_q;

  logic       sclk_rise, mode_chg;
  logic [7:0] byte_w;

  assign sclk_rise = sclk_s_i & ~sclk_q;
  assign mode_chg  = mode_s_i ^ mode_q;
  assign byte_w    = {sh_q, data_s_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q    <= 1'b0;
      mode_q    <= 1'b0;
      bit_cnt_q <= '0;
      idx_q     <= '0;
      sh_q      <= '0;
      hi_q      <= '0;
      rd_flag_q <= 1'b0;
      tx_q      <= '0;
      phase_q   <= PH_IDLE;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
      rd_addr_o <= '0;
    end else begin
      sclk_q  <= sclk_s_i;
      mode_q  <= mode_s_i;
      wr_en_o <= 1'b0;
      if (mode_chg) begin
        bit_cnt_q <= '0;
        idx_q     <= '0;
        if (!mode_s_i) phase_q <= PH_IDLE;
      end else if (sclk_rise) begin
        bit_cnt_q <= bit_cnt_q + 3'd1;
        sh_q      <= byte_w[6:0];
        if (mode_s_i && phase_q == PH_RDBK && (idx_q == 2'd1 || idx_q == 2'd2))
          tx_q <= {tx_q[DATA_W-2:0], 1'b0};
        if (bit_cnt_q == 3'd7) begin
          if (!mode_s_i) begin
            idx_q <= '0;
            if (byte_w[5:0] != DEV_ADDR)      phase_q <= PH_IDLE;
            else if (byte_w[7:6] == OP_CMD)   phase_q <= PH_CMD;
            else if (byte_w[7:6] == OP_RDBK)  phase_q <= PH_RDBK;
            else                              phase_q <= PH_IDLE;
          end else begin
            if (idx_q != 2'd3) idx_q <= idx_q + 2'd1;
            unique case (phase_q)
              PH_CMD: begin
                if (idx_q == 2'd0) begin
                  rd_flag_q <= byte_w[7];
                  if (byte_w[7]) rd_addr_o <= byte_w[6:0];
                  else           wr_addr_o <= byte_w[6:0];
                end else if (idx_q == 2'd1) begin
                  hi_q <= byte_w;
                end else if (idx_q == 2'd2 && !rd_flag_q) begin
                  wr_en_o   <= 1'b1;
                  wr_data_o <= {hi_q, byte_w};
                end
              end
              PH_RDBK: if (idx_q == 2'd0) tx_q <= rd_data_i;
              default: ;
            endcase
          end
        end
      end
    end
  end

  assign oe_o = mode_s_i && phase_q == PH_RDBK && (idx_q == 2'd1 || idx_q == 2'd2);
  assign tx_o = oe_o & tx_q[DATA_W-1];

  // R4
  oe_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_o) |-> $past(sclk_rise));
  // R5
  idle_no_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_IDLE) |=> !wr_en_o);
endmodule

// File: rtl/ctl3_regbank.sv
module ctl3_regbank
  import ctl3_pkg::*;
#(
  parameter int              NREG        = 32,
  parameter int              NCH         = 6,
  parameter logic [ADDR_W-1:0] CH_BASE   = 7'h12,
  parameter logic [ADDR_W-1:0] FEAT_ADDR = 7'h11,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 7'h0F
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [ADDR_W-1:0]      wr_addr_i,
  input  logic [DATA_W-1:0]      wr_data_i,
  input  logic [ADDR_W-1:0]      rd_addr_i,
  input  logic [DATA_W-1:0]      status_i,
  output logic [DATA_W-1:0]      rd_data_o,
  output logic [NREG*DATA_W-1:0] regs_o
);
  localparam int IDX_W = $clog2(NREG);

  logic [DATA_W-1:0] reg_arr [NREG];
  logic              bank_clr;

  assign bank_clr = wr_en_i && wr_addr_i == '0 && wr_data_i[RST_BIT];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam bool_in_ch = (i >= int'(CH_BASE)) && (i < int'(CH_BASE) + NCH);
    localparam bit IS_ODD  = bool_in_ch && ((i - int'(CH_BASE)) % 2 == 0);
    localparam bit IS_EVEN = bool_in_ch && ((i - int'(CH_BASE)) % 2 == 1);
    if (i == int'(STAT_ADDR)) begin : g_stat
      assign reg_arr[i] = '0;
    end else begin : g_rw
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          q <= '0;
        end else if (bank_clr) begin
          q <= '0;
        end else if (wr_en_i) begin
          if (wr_addr_i == ADDR_W'(i))
            q <= wr_data_i;
          else if (wr_addr_i == FEAT_ADDR && IS_ODD)
            q <= wr_data_i;
          else if (wr_addr_i == FEAT_ADDR && IS_EVEN)
            q <= {q[SEL_HI:SEL_LO], wr_data_i[SEL_LO-1:0]};
        end
      end
      assign reg_arr[i] = q;
    end
    assign regs_o[i*DATA_W +: DATA_W] = reg_arr[i];
  end

  always_comb begin
    if (rd_addr_i == STAT_ADDR)             rd_data_o = status_i;
    else if (int'(rd_addr_i) < NREG)        rd_data_o = reg_arr[rd_addr_i[IDX_W-1:0]];
    else                                    rd_data_o = '0;
  end

  // R2
  no_wr_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(regs_o));
  // R6
  bank_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == '0 && wr_data_i[RST_BIT]) |=> regs_o == '0);
  // R7
  stat_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == STAT_ADDR) |=> $stable(regs_o));
  // R8
  bcast_odd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == FEAT_ADDR) |=> reg_arr[int'(CH_BASE)] == $past(wr_data_i));
  // R8
  bcast_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == FEAT_ADDR) |=>
      reg_arr[int'(CH_BASE)+1][SEL_HI:SEL_LO] == $past(reg_arr[int'(CH_BASE)+1][SEL_HI:SEL_LO]));
  // R9
  oob_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && int'(wr_addr_i) >= NREG) |=> $stable(regs_o));
endmodule

// File: rtl/ctl3_slave.sv
module ctl3_slave
  import ctl3_pkg::*;
#(
  parameter logic [5:0] DEV_ADDR    = 6'b010100,
  parameter int         NREG        = 32,
  parameter int         NCH         = 6,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   ctl_clk_i,
  input  logic                   ctl_mode_i,
  input  logic                   ctl_data_i,
  input  logic [DATA_W-1:0]      status_i,
  output logic                   ctl_data_o,
  output logic                   ctl_data_oe_o,
  output logic [NREG*DATA_W-1:0] regs_o
);
  logic [2:0]        sync_w;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [DATA_W-1:0] wr_data, rd_data;

  ctl3_sync #(.STAGES(SYNC_STAGES), .W(3)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i ({ctl_clk_i, ctl_mode_i, ctl_data_i}),
    .sync_o  (sync_w)
  );

  ctl3_frame #(.DEV_ADDR(DEV_ADDR)) u_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sclk_s_i  (sync_w[2]),
    .mode_s_i  (sync_w[1]),
    .data_s_i  (sync_w[0]),
    .rd_data_i (rd_data),
    .wr_en_o   (wr_en),
    .wr_addr_o (wr_addr),
    .wr_data_o (wr_data),
    .rd_addr_o (rd_addr),
    .tx_o      (ctl_data_o),
    .oe_o      (ctl_data_oe_o)
  );

  ctl3_regbank #(.NREG(NREG), .NCH(NCH)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .rd_addr_i (rd_addr),
    .status_i  (status_i),
    .rd_data_o (rd_data),
    .regs_o    (regs_o)
  );

  // R10
  rst_release_chk: assert property (@(posedge clk_i) $fell(rst_ni) |=> !ctl_data_oe_o);
endmodule

// File: tb/tb_ctl3_slave.sv
`timescale 1ns/1ps
module tb_ctl3_slave;
  localparam int NREG = 32;
  localparam int HALF = 8;
  localparam logic [5:0] DEV = 6'b010100;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic ctl_clk = 1'b0, ctl_mode = 1'b0, ctl_data = 1'b0;
  logic [15:0] status = 16'h0;
  logic ctl_data_o, ctl_data_oe_o;
  logic [NREG*16-1:0] regs_o;

  always #2.5 clk = ~clk;

  ctl3_slave dut (
    .clk_i(clk), .rst_ni(rst_ni), .ctl_clk_i(ctl_clk), .ctl_mode_i(ctl_mode),
    .ctl_data_i(ctl_data), .status_i(status), .ctl_data_o(ctl_data_o),
    .ctl_data_oe_o(ctl_data_oe_o), .regs_o(regs_o)
  );

  int n_tests = 0, n_fail = 0, oe_bad = 0;
  logic [15:0] mdl [NREG];
  logic [15:0] exp_q [$];
  string       tag_q [$];
  logic [15:0] got_val;
  event        rd_done;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  initial forever begin
    @(rd_done);
    chk(tag_q.pop_front(), got_val, exp_q.pop_front());
  end

  task automatic mdl_clear();
    for (int i = 0; i < NREG; i++) mdl[i] = '0;
  endtask

  task automatic mdl_write(input logic [6:0] a, input logic [15:0] d);
    if (a == 7'h00 && d[15]) mdl_clear();
    else if (a == 7'h0F || int'(a) >= NREG) ;
    else if (a == 7'h11) begin
      mdl[17] = d;
      for (int c = 0; c < 6; c++)
        if (c % 2 == 0) mdl[18+c] = d;
        else            mdl[18+c] = {mdl[18+c][15:14], d[13:0]};
    end else mdl[a] = d;
  endtask

  function automatic logic [15:0] mdl_read(input logic [6:0] a);
    if (a == 7'h0F) return status;
    if (int'(a) >= NREG) return '0;
    return mdl[a];
  endfunction

  task automatic chk_bank(input string req);
    int bad = -1;
    for (int i = 0; i < NREG; i++)
      if (regs_o[i*16 +: 16] !== mdl[i] && bad < 0) bad = i;
    if (bad < 0) chk(req, 16'h0, 16'h0);
    else chk($sformatf("%s reg %0h", req, bad), regs_o[bad*16 +: 16], mdl[bad]);
  endtask

  task automatic put_byte(input logic m, input logic [7:0] b);
    for (int k = 7; k >= 0; k--) begin
      @(negedge clk);
      ctl_clk = 1'b0; ctl_mode = m; ctl_data = b[k];
      repeat (HALF) @(negedge clk);
      if (ctl_data_oe_o !== 1'b0) oe_bad++;
      ctl_clk = 1'b1;
      repeat (HALF) @(negedge clk);
    end
  endtask

  task automatic get_word(output logic [15:0] w, output int oe_cnt);
    w = '0; oe_cnt = 0;
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      ctl_clk = 1'b0; ctl_mode = 1'b1; ctl_data = 1'b0;
      repeat (HALF) @(negedge clk);
      w = {w[14:0], ctl_data_o};
      if (ctl_data_oe_o === 1'b1) oe_cnt++;
      ctl_clk = 1'b1;
      repeat (HALF) @(negedge clk);
    end
  endtask

  task automatic wr_reg(input logic [1:0] op, input logic [5:0] dv,
                        input logic [6:0] a, input logic [15:0] d);
    put_byte(1'b0, {op, dv});
    put_byte(1'b1, {1'b0, a});
    put_byte(1'b1, d[15:8]);
    put_byte(1'b1, d[7:0]);
    @(negedge clk); ctl_clk = 1'b0;
    repeat (6) @(negedge clk);
    if (op == 2'b01 && dv == DEV) mdl_write(a, d);
  endtask

  task automatic rd_reg(input logic [5:0] dv_rd, input logic [6:0] a, input string req);
    logic [15:0] w; int oe_cnt;
    oe_bad = 0;
    put_byte(1'b0, {2'b01, DEV});
    put_byte(1'b1, {1'b1, a});
    put_byte(1'b0, {2'b11, dv_rd});
    put_byte(1'b1, {1'b1, a});
    chk("R4 no drive before data bytes", 16'(oe_bad), 16'h0);
    if (dv_rd == DEV) begin
      exp_q.push_back(mdl_read(a));
      tag_q.push_back(req);
    end
    get_word(w, oe_cnt);
    if (dv_rd == DEV) begin
      got_val = w;
      ->rd_done;
      chk("R4 drive during data bytes", 16'(oe_cnt), 16'd16);
    end else begin
      chk("R5 foreign read keeps line released", 16'(oe_cnt), 16'd0);
    end
    @(negedge clk); ctl_clk = 1'b0;
    repeat (6) @(negedge clk);
    chk("R4 released after data", {15'h0, ctl_data_oe_o}, 16'h0);
    ctl_mode = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got hung run expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    mdl_clear();
    repeat (5) @(negedge clk);
    // R10 reset state
    chk_bank("R10 reset");
    chk("R10 line released in reset", {15'h0, ctl_data_oe_o}, 16'h0);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk);

    // R1 R2 R3 basic write and read
    wr_reg(2'b01, DEV, 7'h05, 16'hA5C3);
    chk_bank("R1 R2 write 05h");
    rd_reg(DEV, 7'h05, "R3 read 05h");
    wr_reg(2'b01, DEV, 7'h1F, 16'h1234);
    wr_reg(2'b01, DEV, 7'h00, 16'h7001);
    chk_bank("R2 write 1Fh and 00h");
    rd_reg(DEV, 7'h1F, "R3 read 1Fh");
    rd_reg(DEV, 7'h00, "R3 read 00h");

    // R5 foreign device and unknown prefix
    wr_reg(2'b01, 6'b010101, 7'h05, 16'hFFFF);
    chk_bank("R5 foreign device write");
    wr_reg(2'b00, DEV, 7'h05, 16'h0F0F);
    chk_bank("R5 unknown prefix write");
    rd_reg(6'b110100, 7'h05, "R5 foreign read");
    rd_reg(DEV, 7'h05, "R5 05h intact");

    // R7 status register
    status = 16'hBEEF;
    rd_reg(DEV, 7'h0F, "R7 status read");
    wr_reg(2'b01, DEV, 7'h0F, 16'h1111);
    chk_bank("R7 status write ignored");
    rd_reg(DEV, 7'h0F, "R7 status after write");

    // R8 broadcast with preset select bits on even channels
    wr_reg(2'b01, DEV, 7'h13, 16'hC000);
    wr_reg(2'b01, DEV, 7'h15, 16'h4000);
    wr_reg(2'b01, DEV, 7'h17, 16'h8000);
    wr_reg(2'b01, DEV, 7'h12, 16'hC000);
    wr_reg(2'b01, DEV, 7'h11, 16'h3ABC);
    chk_bank("R8 broadcast");
    rd_reg(DEV, 7'h13, "R8 even channel keeps select");
    rd_reg(DEV, 7'h16, "R8 odd channel copy");

    // R9 unimplemented addresses
    wr_reg(2'b01, DEV, 7'h40, 16'h7777);
    chk_bank("R9 high write ignored");
    rd_reg(DEV, 7'h40, "R9 high read zero");

    // R6 bank clear bit
    wr_reg(2'b01, DEV, 7'h00, 16'h8000);
    chk_bank("R6 bank clear");
    rd_reg(DEV, 7'h05, "R6 05h cleared");

    // R10 asynchronous reset
    wr_reg(2'b01, DEV, 7'h05, 16'h1111);
    chk_bank("R2 write before reset");
    #1 rst_ni = 1'b0;
    mdl_clear();
    #1;
    chk_bank("R10 async reset");
    chk("R10 released after reset", {15'h0, ctl_data_oe_o}, 16'h0);

    repeat (5) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule